// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block turns three packed configuration words into the raster timing for an LCD panel. It divides the logic clock into a pixel-clock enable and walks a horizontal position through each line and a vertical position through each frame. From those positions it drives the line sync, the frame sync, a data-enable window over the visible area and an AC-bias toggle for passive panels. Pixel data fetch, DMA and colour lookup belong to other blocks, which use `pix_ce` and `de` to decide when to present each pixel.

Raising `enable` starts a frame at its first line and first pixel. Clearing `enable` does not cut the picture off. The frame in progress runs to its last pixel, then the block goes idle and raises a sticky completion flag. That flag stays set until the block is enabled again, so software can safely reprogram the timing once it sees the flag.

Top module: `lcd_raster_gen`

## Requirements
- R1: After reset the block is idle. `pix_ce`, `hsync`, `vsync`, `de`, `ac_bias` and `frame_done` are all 0 while `misc_cfg` is 0.
- R2: While running, `pix_ce` is high for one logic-clock cycle every D cycles. D is the divider in `misc_cfg[7:0]`, and 255 is the largest value.
- R3: D is raised to a floor. The floor is 2 when `tft_mode` is 1 and 3 when `tft_mode` is 0.
- R4: Each line is measured in pixel ticks and has four parts in this order. Sync lasts `h_cfg[15:10]`+1 ticks. Back porch lasts `h_cfg[31:24]`+1 ticks. Active lasts `h_cfg[9:0]`+1 ticks. Front porch lasts `h_cfg[23:16]`+1 ticks. The raw line sync is high during the sync part.
- R5: Each frame is measured in lines and has four parts in this order. Sync lasts `v_cfg[15:10]`+1 lines. Back porch lasts exactly `v_cfg[31:24]` lines. Active lasts `v_cfg[9:0]`+1 lines. Front porch lasts exactly `v_cfg[23:16]` lines. Both porches may be zero. The raw frame sync is high during the sync lines.
- R6: The raw data-enable is high only on active pixels of active lines.
- R7: `misc_cfg[20]` inverts `hsync`, `misc_cfg[21]` inverts `vsync` and `misc_cfg[22]` inverts `de`. These inversions also apply while idle. `misc_cfg[25:23]` has no effect on any output.
- R8: `ac_bias` is 0 when a run starts. If N = `misc_cfg[15:8]` is nonzero, `ac_bias` toggles after every N completed lines, and the line count carries across frame boundaries. If N is 0, it toggles at the end of each frame.
- R9: When `enable` is 0 at the last pixel tick of a frame, the block stops after that tick. No further `pix_ce` pulses appear, and the syncs and `de` return to their inactive levels. Clearing `enable` earlier never shortens the current frame.
- R10: `frame_done` is set when the block stops as described in R9. It stays set while the block is idle and clears on the clock edge at which `enable` restarts the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; clearing it stops the block at the end of the current frame |
| tft_mode | input | 1 | 1 selects an active-matrix panel, 0 a passive panel |
| h_cfg | input | 32 | Horizontal timing word |
| v_cfg | input | 32 | Vertical timing word |
| misc_cfg | input | 32 | Divider [7:0], AC-bias count [15:8], polarity [25:20] |
| pix_ce | output | 1 | One-cycle pixel-clock enable |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data-enable window |
| ac_bias | output | 1 | AC-bias toggle |
| frame_done | output | 1 | Sticky flag set after a graceful stop |

## Verification
The bench uses a small raster of 15 ticks per line and 8 lines per frame, so every run lasts only a few hundred ticks. This keeps every porch, sync edge and frame boundary within reach many times over, including a vertical layout with both porches at zero. The divider is exercised at its clamped floors in both panel modes, at a middle value and at the maximum of 255. The bench also uses AC-bias counts of 0, 2 and 3, so toggles fall inside a frame, on frame boundaries and across them.

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        tft_mode,
  input  logic [31:0] h_cfg,
  input  logic [31:0] v_cfg,
  input  logic [31:0] misc_cfg,
  output logic        pix_ce,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic        ac_bias,
  output logic        frame_done
);
  localparam int CW = 12;
  localparam int DW = 8;

  logic [DW-1:0] div_raw, div_floor, div_eff, acb_n;
  logic [CW-1:0] h_sw, h_bp, h_act, h_fp, h_beg, h_end, h_tot;
  logic [CW-1:0] v_sw, v_bp, v_act, v_fp, v_beg, v_end, v_tot;

  assign div_raw   = misc_cfg[7:0];
  assign acb_n     = misc_cfg[15:8];
  assign div_floor = tft_mode ? DW'(2) : DW'(3);
  assign div_eff   = (div_raw < div_floor) ? div_floor : div_raw;

  assign h_sw  = CW'(h_cfg[15:10]) + CW'(1);
  assign h_bp  = CW'(h_cfg[31:24]) + CW'(1);
  assign h_act = CW'(h_cfg[9:0])   + CW'(1);
  assign h_fp  = CW'(h_cfg[23:16]) + CW'(1);
  assign h_beg = h_sw + h_bp;
  assign h_end = h_beg + h_act;
  assign h_tot = h_end + h_fp;

  assign v_sw  = CW'(v_cfg[15:10]) + CW'(1);
  assign v_bp  = CW'(v_cfg[31:24]);
  assign v_act = CW'(v_cfg[9:0])   + CW'(1);
  assign v_fp  = CW'(v_cfg[23:16]);
  assign v_beg = v_sw + v_bp;
  assign v_end = v_beg + v_act;
  assign v_tot = v_end + v_fp;

  logic          run, ac_q, done_q;
  logic [DW-1:0] div_cnt, acl;
  logic [CW-1:0] hcnt, vcnt;
  logic          tick, line_end, frame_end;
  logic          hs_raw, vs_raw, de_raw;

  assign tick      = run && (div_cnt >= div_eff - DW'(1));
  assign line_end  = tick && (hcnt == h_tot - CW'(1));
  assign frame_end = line_end && (vcnt == v_tot - CW'(1));

  assign hs_raw = run && (hcnt < h_sw);
  assign vs_raw = run && (vcnt < v_sw);
  assign de_raw = run && (hcnt >= h_beg) && (hcnt < h_end)
                      && (vcnt >= v_beg) && (vcnt < v_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      div_cnt <= '0;
      hcnt    <= '0;
      vcnt    <= '0;
      acl     <= '0;
      ac_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (!run) begin
      if (enable) begin
        run     <= 1'b1;
        div_cnt <= '0;
        hcnt    <= '0;
        vcnt    <= '0;
        acl     <= '0;
        ac_q    <= 1'b0;
        done_q  <= 1'b0;
      end
    end else begin
      div_cnt <= tick ? '0 : div_cnt + DW'(1);
      if (tick)
        hcnt <= line_end ? '0 : hcnt + CW'(1);
      if (line_end)
        vcnt <= frame_end ? '0 : vcnt + CW'(1);
      if (acb_n == '0) begin
        if (frame_end) ac_q <= ~ac_q;
      end else if (line_end) begin
        if (acl == acb_n - DW'(1)) begin
          acl  <= '0;
          ac_q <= ~ac_q;
        end else begin
          acl <= acl + DW'(1);
        end
      end
      if (frame_end && !enable) begin
        run    <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  wire unused_cfg_bits = ^{misc_cfg[31:23], misc_cfg[19:16]};

  assign pix_ce     = tick;
  assign hsync      = hs_raw ^ misc_cfg[20];
  assign vsync      = vs_raw ^ misc_cfg[21];
  assign de         = de_raw ^ misc_cfg[22];
  assign ac_bias    = ac_q;
  assign frame_done = done_q;
endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic run,
  input logic pix_ce,
  input logic frame_done,
  input logic hs_raw,
  input logic vs_raw,
  input logic de_raw
);
  assert_ce_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pix_ce);
  assert_stop_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !$past(enable));
  assert_done_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !run);
  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && enable) |=> !frame_done);
  assert_ce_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);
  assert_de_outside_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> (!hs_raw && !vs_raw));
endmodule

bind lcd_raster_gen lcd_raster_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .pix_ce(pix_ce),
  .frame_done(frame_done), .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw)
);

// File: tb/tb_lcd_raster_gen.sv
module tb_lcd_raster_gen;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, tft_mode = 1'b1;
  logic [31:0] h_cfg = '0, v_cfg = '0, misc_cfg = '0;
  logic pix_ce, hsync, vsync, de, ac_bias, frame_done;

  lcd_raster_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tft_mode(tft_mode),
    .h_cfg(h_cfg), .v_cfg(v_cfg), .misc_cfg(misc_cfg), .pix_ce(pix_ce),
    .hsync(hsync), .vsync(vsync), .de(de), .ac_bias(ac_bias),
    .frame_done(frame_done)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [3:0] q[$];
  logic [2:0] exp_pol = '0;
  int exp_div = 2;
  bit first_pulse = 1'b1;
  longint cyc = 0, last_pulse = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && pix_ce) begin
      if (!first_pulse)
        check(cyc - last_pulse == exp_div, "R2/R3 tick spacing",
              int'(cyc - last_pulse), exp_div);
      first_pulse = 1'b0;
      last_pulse = cyc;
      if (q.size() == 0) begin
        check(1'b0, "R9 tick after stop", 1, 0);
      end else begin
        logic [3:0] e;
        logic [3:0] a;
        e = q.pop_front();
        e[3:1] = e[3:1] ^ {exp_pol[0], exp_pol[1], exp_pol[2]};
        a = {hsync, vsync, de, ac_bias};
        check(a == e, "R4/R5/R6/R7/R8 pixel {hs,vs,de,ac}", a, e);
      end
    end
  end

  // Pushes the expected pixel sequence, runs, and stops gracefully in the last frame.
  task automatic run_test(input int nfr, input logic [31:0] h, input logic [31:0] v,
                          input logic [31:0] m, input bit tft, input int div);
    int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp, htot, vtot, acb, lines;
    @(negedge clk);
    h_cfg = h; v_cfg = v; misc_cfg = m; tft_mode = tft;
    hsw = h[15:10] + 1; hbp = h[31:24] + 1; hact = h[9:0] + 1; hfp = h[23:16] + 1;
    vsw = v[15:10] + 1; vbp = v[31:24];     vact = v[9:0] + 1; vfp = v[23:16];
    htot = hsw + hbp + hact + hfp; vtot = vsw + vbp + vact + vfp;
    acb = m[15:8];
    lines = 0;
    for (int f = 0; f < nfr; f++)
      for (int l = 0; l < vtot; l++) begin
        for (int x = 0; x < htot; x++) begin
          logic [3:0] it;
          it[3] = (x < hsw);
          it[2] = (l < vsw);
          it[1] = (l >= vsw + vbp) && (l < vsw + vbp + vact) &&
                  (x >= hsw + hbp) && (x < hsw + hbp + hact);
          it[0] = (acb == 0) ? f[0] : ((lines / acb) % 2 == 1);
          q.push_back(it);
        end
        lines++;
      end
    exp_pol = m[22:20];
    exp_div = div;
    first_pulse = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    check(frame_done == 1'b0, "R10 done cleared on restart", frame_done, 0);
    wait (q.size() < htot * vtot / 2);
    @(negedge clk);
    enable = 1'b0;
    wait (q.size() == 0);
    repeat (2 * div + 3) @(negedge clk);
    check(frame_done == 1'b1, "R10 done after stop", frame_done, 1);
    check(pix_ce == 1'b0, "R9 no tick when idle", pix_ce, 0);
    check({hsync, vsync, de} == {m[20], m[21], m[22]}, "R9/R7 idle levels",
          {hsync, vsync, de}, {m[20], m[21], m[22]});
    repeat (5) @(negedge clk);
    check(frame_done == 1'b1, "R10 done held while idle", frame_done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  localparam logic [31:0] H_A = {8'd2, 8'd1, 6'd1, 10'd7};
  localparam logic [31:0] V_A = {8'd2, 8'd1, 6'd0, 10'd3};
  localparam logic [31:0] V_B = {8'd0, 8'd0, 6'd1, 10'd3};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({pix_ce, hsync, vsync, de, ac_bias, frame_done} == 6'b0, "R1 reset outputs",
          {pix_ce, hsync, vsync, de, ac_bias, frame_done}, 0);
    // R2 R4 R5 R6: TFT, divider 2, AC bias per frame
    run_test(2, H_A, V_A, {6'd0, 6'd0, 4'd0, 8'd0, 8'd2}, 1'b1, 2);
    // R3 passive floor: programmed 1 becomes 3; zero vertical porches
    run_test(2, H_A, V_B, {6'd0, 6'd0, 4'd0, 8'd2, 8'd1}, 1'b0, 3);
    // R3 TFT floor: programmed 0 becomes 2
    run_test(1, H_A, V_A, {6'd0, 6'd0, 4'd0, 8'd0, 8'd0}, 1'b1, 2);
    // R7 all polarity bits set including unused ones; R8 count 3; divider 5
    run_test(3, H_A, V_A, {6'd0, 6'b111111, 4'd0, 8'd3, 8'd5}, 1'b0, 5);
    // R2 maximum divider
    run_test(1, H_A, V_B, {6'd0, 6'd0, 4'd0, 8'd1, 8'd255}, 1'b1, 255);
    report();
  end
endmodule